// File: doc/BRIEF.md
# CAN Mailbox Filter and Arbiter

This block sits next to a CAN protocol engine and owns eight message mailboxes. Every decoded frame that arrives from the engine is tested against each receive mailbox. The test uses a per-mailbox identifier, a per-mailbox mask and a format bit that selects standard or extended identifiers. The frame is written into one chosen mailbox together with a 16-bit timestamp, and that mailbox's ready flag goes high. Receive mailboxes that share a filter form a chained buffer. A mailbox in keep mode rejects a new frame while it is full. A mailbox in overwrite mode takes the new frame and records that the old one was lost.

For transmission, software loads a mailbox and issues a send command. Among all pending transmit mailboxes, the arbiter presents the one with the most urgent priority to the engine. It holds that frame steady until the engine reports completion, then timestamps the mailbox and clears its pending state. Software reaches every mailbox through a simple 32-bit register port with a one-cycle read latency.

Top module: `can_mailbox_unit`

## Requirements
- R1: After synchronous reset every mailbox is off (mode 0), `mb_ready` is 0, `tx_valid` is 0, and every status word reads 0.
- R2: An extended frame (`rx_ide`=1) is stored in a receive mailbox with format bit 1 when ((rx_id XOR mailbox id) AND mailbox mask) is zero. A frame that fails this test is not stored.
- R3: For a standard frame (`rx_ide`=0), only identifier bits 28:18 are compared. A frame whose IDE bit differs from the mailbox format bit never matches.
- R4: A keep-mode mailbox (mode 3) whose ready flag is set rejects further matching frames, and its data and status stay unchanged.
- R5: An overwrite-mode mailbox (mode 2) that is full and matched, with no free matching mailbox available, takes the new frame and sets its overwrite flag (status bit 22).
- R6: Among matching mailboxes, the lowest-numbered one with ready clear takes the frame. Its `mb_ready` bit is visible one clock after `rx_valid`, and at most one mailbox is filled per frame.
- R7: A 16-bit timer is 0 in the first cycle after reset and increments every clock. A mailbox stores the timer value from the cycle in which its frame is received, or from the cycle in which `tx_done` completes its transmission.
- R8: Among pending transmit mailboxes, the one with the smallest 4-bit priority value (mode word bits 7:4) is sent first, and equal values go to the lower index. `tx_id` and `tx_data` stay stable while `tx_valid` is high and `tx_done` is low.
- R9: `tx_done` drops `tx_valid` on the next clock, clears that mailbox's pending flag (status bit 21) and stamps it.
- R10: Writing the command word (select 5) with bit 9 set clears the mailbox's ready and overwrite flags, so it can accept a new frame. Bit 8 with bits 3:0 as DLC requests transmission when the mailbox is in mode 1.
- R11: The register port uses these selects: 0 identifier, 1 mask, 2 mode word ({prio[7:4], ide[2], mode[1:0]}), 3 data bytes 0-3 (`rx_data[31:0]`), 4 data bytes 4-7, 5 status or command. A read returns its 32-bit word one clock after `reg_rd`, with `reg_rvalid` high. The status word is {overwrite[22], pending[21], ready[20], dlc[19:16], timestamp[15:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe of a decoded frame |
| rx_id | input | 29 | Received identifier (standard IDs in bits 28:18) |
| rx_ide | input | 1 | 1 = extended frame |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 64 | Received data bytes, byte 0 in bits 7:0 |
| tx_valid | output | 1 | Frame offered to the engine |
| tx_id | output | 29 | Identifier to send |
| tx_ide | output | 1 | Format of frame to send |
| tx_dlc | output | 4 | Length code to send |
| tx_data | output | 64 | Data to send |
| tx_done | input | 1 | Engine finished the offered frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_mb | input | 3 | Mailbox index |
| reg_sel | input | 3 | Word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| mb_ready | output | 8 | Per-mailbox ready flags |

## Verification
Extended identifiers are sent with differences only in masked-off bits and with a difference in one unmasked bit, which separates the mask logic from a plain equality compare. Standard frames carry junk in the low 18 bits, and a frame with matching bits but the wrong IDE bit must be rejected, which separates the format test from the bit compare. A run of frames into a two-mailbox chain, followed by a release, shows that placement favours the lowest free slot, that a full buffer rejects, and that an overwrite mailbox marks loss. Four transmit requests are queued while the engine is busy: one urgent, two with equal priority and one low. Their send order exposes both the priority compare and the index tie-break.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
  typedef enum logic [1:0] {
    MB_OFF     = 2'd0,
    MB_TX      = 2'd1,
    MB_RX_OVW  = 2'd2,
    MB_RX_KEEP = 2'd3
  } mb_mode_e;

  localparam logic [2:0] SEL_ID   = 3'd0;
  localparam logic [2:0] SEL_MASK = 3'd1;
  localparam logic [2:0] SEL_MODE = 3'd2;
  localparam logic [2:0] SEL_DLO  = 3'd3;
  localparam logic [2:0] SEL_DHI  = 3'd4;
  localparam logic [2:0] SEL_CMD  = 3'd5;
endpackage

// File: rtl/can_mb_accept.sv
module can_mb_accept #(
  parameter int IDW  = 29,
  parameter int STDW = 11
) (
  input  logic [IDW-1:0] mb_id,
  input  logic [IDW-1:0] mb_mask,
  input  logic           mb_ide,
  input  logic           mb_rx_en,
  input  logic [IDW-1:0] fr_id,
  input  logic           fr_ide,
  output logic           hit
);
  localparam logic [IDW-1:0] STD_SPAN = {{STDW{1'b1}}, {(IDW-STDW){1'b0}}};
  logic [IDW-1:0] span;

  always_comb begin
    span = fr_ide ? '1 : STD_SPAN;
    hit  = mb_rx_en && (mb_ide == fr_ide) &&
           (((fr_id ^ mb_id) & mb_mask & span) == '0);
  end
endmodule

// File: rtl/can_mb_first.sv
module can_mb_first #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/can_mb_tx_arb.sv
module can_mb_tx_arb #(
  parameter int N   = 8,
  parameter int PRW = 4,
  parameter int IW  = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  input  logic [N*PRW-1:0] prio_flat,
  output logic             found,
  output logic [IW-1:0]    idx
);
  logic [PRW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!found || prio_flat[i*PRW +: PRW] < best)) begin
        found = 1'b1;
        best  = prio_flat[i*PRW +: PRW];
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/can_mailbox_unit.sv
module can_mailbox_unit
  import can_mb_pkg::*;
#(
  parameter int NMB = 8,
  parameter int IDW = 29,
  parameter int TSW = 16,
  parameter int PRW = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_valid,
  input  logic [IDW-1:0]         rx_id,
  input  logic                   rx_ide,
  input  logic [3:0]             rx_dlc,
  input  logic [63:0]            rx_data,
  output logic                   tx_valid,
  output logic [IDW-1:0]         tx_id,
  output logic                   tx_ide,
  output logic [3:0]             tx_dlc,
  output logic [63:0]            tx_data,
  input  logic                   tx_done,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [$clog2(NMB)-1:0] reg_mb,
  input  logic [2:0]             reg_sel,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   reg_rvalid,
  output logic [NMB-1:0]         mb_ready
);
  localparam int MBW    = $clog2(NMB);
  localparam int REGW   = 32;
  localparam int ST_DLC = TSW;
  localparam int ST_RDY = TSW + 4;
  localparam int ST_PND = TSW + 5;
  localparam int ST_OVR = TSW + 6;

  mb_mode_e       mode_q [NMB];
  logic [IDW-1:0] id_q   [NMB];
  logic [IDW-1:0] mask_q [NMB];
  logic [PRW-1:0] prio_q [NMB];
  logic [3:0]     dlc_q  [NMB];
  logic [63:0]    data_q [NMB];
  logic [TSW-1:0] ts_q   [NMB];
  logic [NMB-1:0] ide_q, ready_q, pend_q, ovr_q;
  logic [TSW-1:0] timer;
  logic           busy;
  logic [MBW-1:0] cur;

  logic [NMB-1:0]     hit, is_ovw;
  logic [NMB*PRW-1:0] prio_flat;
  logic               free_any, ovw_any, arb_found;
  logic [MBW-1:0]     free_idx, ovw_idx, arb_idx, rx_idx;
  logic               rx_take, rx_clobber;
  logic [REGW-1:0]    rd_word;

  for (genvar g = 0; g < NMB; g++) begin : g_mb
    can_mb_accept #(.IDW(IDW)) u_acc (
      .mb_id   (id_q[g]),
      .mb_mask (mask_q[g]),
      .mb_ide  (ide_q[g]),
      .mb_rx_en(mode_q[g] == MB_RX_OVW || mode_q[g] == MB_RX_KEEP),
      .fr_id   (rx_id),
      .fr_ide  (rx_ide),
      .hit     (hit[g])
    );
    assign is_ovw[g]                = (mode_q[g] == MB_RX_OVW);
    assign prio_flat[g*PRW +: PRW]  = prio_q[g];
  end

  can_mb_first #(.N(NMB)) u_free (
    .req(hit & ~ready_q), .any(free_any), .idx(free_idx));
  can_mb_first #(.N(NMB)) u_ovw (
    .req(hit & is_ovw), .any(ovw_any), .idx(ovw_idx));
  can_mb_tx_arb #(.N(NMB), .PRW(PRW)) u_arb (
    .pend(pend_q), .prio_flat(prio_flat), .found(arb_found), .idx(arb_idx));

  always_comb begin
    rx_take    = rx_valid && (free_any || ovw_any);
    rx_clobber = !free_any;
    rx_idx     = free_any ? free_idx : ovw_idx;
  end

  always_comb begin
    rd_word = '0;
    case (reg_sel)
      SEL_ID:   rd_word = REGW'(id_q[reg_mb]);
      SEL_MASK: rd_word = REGW'(mask_q[reg_mb]);
      SEL_MODE: begin
        rd_word[1:0]       = mode_q[reg_mb];
        rd_word[2]         = ide_q[reg_mb];
        rd_word[4 +: PRW]  = prio_q[reg_mb];
      end
      SEL_DLO:  rd_word = data_q[reg_mb][31:0];
      SEL_DHI:  rd_word = data_q[reg_mb][63:32];
      SEL_CMD: begin
        rd_word[TSW-1:0]    = ts_q[reg_mb];
        rd_word[ST_DLC +: 4] = dlc_q[reg_mb];
        rd_word[ST_RDY]     = ready_q[reg_mb];
        rd_word[ST_PND]     = pend_q[reg_mb];
        rd_word[ST_OVR]     = ovr_q[reg_mb];
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timer      <= '0;
      ready_q    <= '0;
      pend_q     <= '0;
      ovr_q      <= '0;
      ide_q      <= '0;
      busy       <= 1'b0;
      cur        <= '0;
      tx_id      <= '0;
      tx_ide     <= 1'b0;
      tx_dlc     <= '0;
      tx_data    <= '0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      for (int i = 0; i < NMB; i++) begin
        mode_q[i] <= MB_OFF;
        id_q[i]   <= '0;
        mask_q[i] <= '0;
        prio_q[i] <= '0;
        dlc_q[i]  <= '0;
        data_q[i] <= '0;
        ts_q[i]   <= '0;
      end
    end else begin
      timer      <= timer + 1'b1;
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_word;

      if (reg_wr) begin
        case (reg_sel)
          SEL_ID:   id_q[reg_mb]   <= reg_wdata[IDW-1:0];
          SEL_MASK: mask_q[reg_mb] <= reg_wdata[IDW-1:0];
          SEL_MODE: begin
            mode_q[reg_mb] <= mb_mode_e'(reg_wdata[1:0]);
            ide_q[reg_mb]  <= reg_wdata[2];
            prio_q[reg_mb] <= reg_wdata[4 +: PRW];
          end
          SEL_DLO:  data_q[reg_mb][31:0]  <= reg_wdata;
          SEL_DHI:  data_q[reg_mb][63:32] <= reg_wdata;
          SEL_CMD: begin
            if (reg_wdata[8] && mode_q[reg_mb] == MB_TX) begin
              pend_q[reg_mb] <= 1'b1;
              dlc_q[reg_mb]  <= reg_wdata[3:0];
            end
            if (reg_wdata[9]) begin
              ready_q[reg_mb] <= 1'b0;
              ovr_q[reg_mb]   <= 1'b0;
            end
          end
          default: ;
        endcase
      end

      if (rx_take) begin
        data_q[rx_idx]  <= rx_data;
        dlc_q[rx_idx]   <= rx_dlc;
        ts_q[rx_idx]    <= timer;
        ready_q[rx_idx] <= 1'b1;
        if (rx_clobber) ovr_q[rx_idx] <= 1'b1;
      end

      if (busy) begin
        if (tx_done) begin
          busy         <= 1'b0;
          pend_q[cur]  <= 1'b0;
          ts_q[cur]    <= timer;
        end
      end else if (arb_found) begin
        busy    <= 1'b1;
        cur     <= arb_idx;
        tx_id   <= id_q[arb_idx];
        tx_ide  <= ide_q[arb_idx];
        tx_dlc  <= dlc_q[arb_idx];
        tx_data <= data_q[arb_idx];
      end
    end
  end

  assign tx_valid = busy;
  assign mb_ready = ready_q;
endmodule

// File: rtl/can_mb_checker.sv
module can_mb_checker #(
  parameter int NMB = 8,
  parameter int IDW = 29
) (
  input logic           clk,
  input logic           rst,
  input logic           rx_valid,
  input logic           tx_valid,
  input logic [IDW-1:0] tx_id,
  input logic [63:0]    tx_data,
  input logic           tx_done,
  input logic           reg_rd,
  input logic           reg_rvalid,
  input logic [NMB-1:0] mb_ready
);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (mb_ready == '0 && !tx_valid));

  p_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (|(mb_ready & ~$past(mb_ready))) |-> $past(rx_valid));

  p_one_slot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(mb_ready & ~$past(mb_ready)) <= 1);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_id) && $stable(tx_data)));

  p_tx_release_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_done) |=> !tx_valid);

  p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
endmodule

bind can_mailbox_unit can_mb_checker #(.NMB(NMB), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_id(tx_id), .tx_data(tx_data), .tx_done(tx_done),
  .reg_rd(reg_rd), .reg_rvalid(reg_rvalid), .mb_ready(mb_ready)
);

// File: tb/can_mailbox_unit_tb.sv
module can_mailbox_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [28:0] rx_id = '0;
  logic        rx_ide = 1'b0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        tx_valid, tx_ide;
  logic [28:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        tx_done = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_mb = '0, reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_rvalid;
  logic [7:0]  mb_ready;

  int checks = 0;
  int errors = 0;
  logic [15:0] tcount = '0;
  logic        tx_prev = 1'b0;

  logic [31:0] rq_exp[$];
  string       rq_tag[$];
  logic [28:0] tq_id[$];
  logic [31:0] tq_dlo[$];

  always #10 clk = ~clk;

  can_mailbox_unit u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide),
    .rx_dlc(rx_dlc), .rx_data(rx_data), .tx_valid(tx_valid), .tx_id(tx_id),
    .tx_ide(tx_ide), .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_done(tx_done),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_mb(reg_mb), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .mb_ready(mb_ready)
  );

  // R7 timer model: 0 in the first cycle after reset, +1 per clock
  always @(posedge clk) tcount <= rst ? 16'd0 : tcount + 16'd1;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(input logic [15:0] ts, input logic [3:0] dlc,
                                       input bit rdy, input bit pnd, input bit ovr);
    return {9'd0, ovr, pnd, rdy, dlc, ts};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (rq_exp.size() == 0) check(1'b0, "R11 unexpected read", 64'(reg_rdata), 64'd0);
      else begin
        logic [31:0] e;
        string t;
        e = rq_exp.pop_front();
        t = rq_tag.pop_front();
        check(reg_rdata == e, t, 64'(reg_rdata), 64'(e));
      end
    end
    if (!rst && tx_valid && !tx_prev) begin
      if (tq_id.size() == 0) check(1'b0, "R8 unexpected frame", 64'(tx_id), 64'd0);
      else begin
        logic [28:0] ei;
        logic [31:0] ed;
        ei = tq_id.pop_front();
        ed = tq_dlo.pop_front();
        check(tx_id == ei && tx_data[31:0] == ed, "R8 send order",
              {3'd0, tx_id, tx_data[31:0]}, {3'd0, ei, ed});
      end
    end
    tx_prev = tx_valid;
  end

  task automatic wr(input logic [2:0] mb, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_mb = mb; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] mb, input logic [2:0] sel,
                        input logic [31:0] exp, input string tag);
    rq_exp.push_back(exp);
    rq_tag.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_mb = mb; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_rx(input logic [28:0] id, input bit ide, input logic [3:0] dlc,
                         input logic [63:0] d, output logic [15:0] ts);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_ide = ide; rx_dlc = dlc; rx_data = d;
    ts = tcount;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic finish_tx(output logic [15:0] ts);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    tx_done = 1'b1;
    ts = tcount;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] t0, t1, t2, t3, t4, t5, tx0, ta, tb, tc, td;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(mb_ready == 8'h00, "R1 ready after reset", 64'(mb_ready), 64'h0);
    check(tx_valid == 1'b0, "R1 tx idle after reset", 64'(tx_valid), 64'h0);
    rd_exp(3'd0, 3'd5, 32'h0, "R1 status mb0");
    rd_exp(3'd3, 3'd2, 32'h0, "R1 mode mb3");

    // configuration
    wr(3'd0, 3'd0, 32'h1234_5678);
    wr(3'd0, 3'd1, 32'h1FFF_FF00);
    wr(3'd0, 3'd2, 32'h0000_0007);
    wr(3'd1, 3'd0, 32'h048C_0000);
    wr(3'd1, 3'd1, 32'h1FFF_FFFF);
    wr(3'd1, 3'd2, 32'h0000_0002);
    for (int m = 2; m < 4; m++) begin
      wr(3'(m), 3'd0, 32'h0000_0AB0);
      wr(3'(m), 3'd1, 32'h1FFF_FFF0);
      wr(3'(m), 3'd2, 32'h0000_0007);
    end
    rd_exp(3'd0, 3'd0, 32'h1234_5678, "R11 id readback");
    rd_exp(3'd0, 3'd1, 32'h1FFF_FF00, "R11 mask readback");
    rd_exp(3'd0, 3'd2, 32'h0000_0007, "R11 mode readback");

    // R2 unmasked bit differs: rejected
    send_rx(29'h1234_5778, 1'b1, 4'd8, 64'h0, tx0);
    check(mb_ready == 8'h00, "R2 unmasked mismatch rejected", 64'(mb_ready), 64'h0);
    // R2 masked bits differ: accepted
    send_rx(29'h1234_56AB, 1'b1, 4'd8, 64'h1111_2222_3333_4444, t0);
    check(mb_ready == 8'h01, "R2 masked match stored", 64'(mb_ready), 64'h1);
    rd_exp(3'd0, 3'd3, 32'h3333_4444, "R2 data low");
    rd_exp(3'd0, 3'd4, 32'h1111_2222, "R2 data high");
    rd_exp(3'd0, 3'd5, stat(t0, 4'd8, 1, 0, 0), "R7 rx stamp mb0");

    // R4 keep mode full
    send_rx(29'h1234_5600, 1'b1, 4'd4, 64'hDEAD_BEEF_CAFE_F00D, tx0);
    rd_exp(3'd0, 3'd3, 32'h3333_4444, "R4 data kept");
    rd_exp(3'd0, 3'd5, stat(t0, 4'd8, 1, 0, 0), "R4 status kept");

    // R10 release then accept again
    wr(3'd0, 3'd5, 32'h0000_0200);
    check(mb_ready == 8'h00, "R10 release clears ready", 64'(mb_ready), 64'h0);
    rd_exp(3'd0, 3'd5, stat(t0, 4'd8, 0, 0, 0), "R10 status after release");
    send_rx(29'h1234_5699, 1'b1, 4'd2, 64'h0000_0000_5555_6666, t1);
    check(mb_ready == 8'h01, "R10 accepts after release", 64'(mb_ready), 64'h1);
    rd_exp(3'd0, 3'd3, 32'h5555_6666, "R10 new data");
    rd_exp(3'd0, 3'd5, stat(t1, 4'd2, 1, 0, 0), "R7 second stamp mb0");

    // R3 standard frame, low 18 bits ignored
    send_rx(29'h048F_FFFF, 1'b0, 4'd3, 64'hAAAA_BBBB_CCCC_DDDD, t2);
    check(mb_ready == 8'h03, "R3 standard match", 64'(mb_ready), 64'h3);
    // R3 IDE mismatch with equal bits
    send_rx(29'h048C_0000, 1'b1, 4'd5, 64'h9999, tx0);
    check(mb_ready == 8'h03, "R3 ide mismatch rejected", 64'(mb_ready), 64'h3);
    rd_exp(3'd1, 3'd3, 32'hCCCC_DDDD, "R3 data unchanged by ext frame");
    rd_exp(3'd1, 3'd5, stat(t2, 4'd3, 1, 0, 0), "R3 status no overwrite");

    // R5 overwrite
    send_rx(29'h048C_1234, 1'b0, 4'd6, 64'h7777_8888_9999_AAAA, t3);
    rd_exp(3'd1, 3'd3, 32'h9999_AAAA, "R5 data replaced");
    rd_exp(3'd1, 3'd5, stat(t3, 4'd6, 1, 0, 1), "R5 overwrite flag");
    wr(3'd1, 3'd5, 32'h0000_0200);
    rd_exp(3'd1, 3'd5, stat(t3, 4'd6, 0, 0, 0), "R10 overwrite flag cleared");

    // R6 chained buffer
    send_rx(29'h0000_0AB1, 1'b1, 4'd1, 64'h1, t4);
    check(mb_ready == 8'h05, "R6 chain first slot", 64'(mb_ready), 64'h05);
    send_rx(29'h0000_0AB2, 1'b1, 4'd1, 64'h2, t5);
    check(mb_ready == 8'h0D, "R6 chain second slot", 64'(mb_ready), 64'h0D);
    send_rx(29'h0000_0AB3, 1'b1, 4'd1, 64'h3, tx0);
    check(mb_ready == 8'h0D, "R6 chain full rejects", 64'(mb_ready), 64'h0D);
    rd_exp(3'd2, 3'd3, 32'h1, "R6 mb2 data");
    rd_exp(3'd3, 3'd3, 32'h2, "R6 mb3 data");
    rd_exp(3'd2, 3'd5, stat(t4, 4'd1, 1, 0, 0), "R7 stamp mb2");
    rd_exp(3'd3, 3'd5, stat(t5, 4'd1, 1, 0, 0), "R7 stamp mb3");
    wr(3'd2, 3'd5, 32'h0000_0200);
    send_rx(29'h0000_0AB4, 1'b1, 4'd1, 64'h4, tx0);
    check(mb_ready == 8'h0D, "R6 refill lowest free", 64'(mb_ready), 64'h0D);
    rd_exp(3'd2, 3'd3, 32'h4, "R6 refill data");

    // R8 transmit arbitration
    wr(3'd7, 3'd0, 32'h1ABC_DEF0);
    wr(3'd7, 3'd2, 32'h0000_0005);
    wr(3'd7, 3'd3, 32'h7777_0007);
    wr(3'd4, 3'd0, 32'h0000_0104); wr(3'd4, 3'd2, 32'h31); wr(3'd4, 3'd3, 32'h4);
    wr(3'd5, 3'd0, 32'h0000_0105); wr(3'd5, 3'd2, 32'h11); wr(3'd5, 3'd3, 32'h5);
    wr(3'd6, 3'd0, 32'h0000_0106); wr(3'd6, 3'd2, 32'h11); wr(3'd6, 3'd3, 32'h6);
    tq_id.push_back(29'h1ABC_DEF0); tq_dlo.push_back(32'h7777_0007);
    tq_id.push_back(29'h105);       tq_dlo.push_back(32'h5);
    tq_id.push_back(29'h106);       tq_dlo.push_back(32'h6);
    tq_id.push_back(29'h104);       tq_dlo.push_back(32'h4);
    wr(3'd7, 3'd5, 32'h0000_0108);
    wr(3'd4, 3'd5, 32'h0000_0102);
    wr(3'd5, 3'd5, 32'h0000_0101);
    wr(3'd6, 3'd5, 32'h0000_0103);
    rd_exp(3'd4, 3'd5, stat(16'd0, 4'd2, 0, 1, 0), "R8 pending flag set");
    finish_tx(ta);
    finish_tx(tb);
    finish_tx(tc);
    finish_tx(td);
    check(tx_valid == 1'b0, "R9 idle after last done", 64'(tx_valid), 64'h0);
    rd_exp(3'd7, 3'd5, stat(ta, 4'd8, 0, 0, 0), "R9 mb7 stamp and clear");
    rd_exp(3'd4, 3'd5, stat(td, 4'd2, 0, 0, 0), "R9 mb4 stamp and clear");

    repeat (4) @(negedge clk);
    check(rq_exp.size() == 0, "R11 all reads returned", 64'(rq_exp.size()), 64'h0);
    check(tq_id.size() == 0, "R8 all frames sent", 64'(tq_id.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule